// File: doc/BRIEF.md
# ECP Reverse-Channel Run-Length Expander

This block sits behind the receive side of an IEEE 1284 ECP parallel port. Every byte that arrives from the peripheral is tagged with a command/data flag. Data bytes go into a plain output byte stream that feeds a receive FIFO. Command bytes are consumed inside the block. A command byte either sets a repeat count for the next data byte or announces a channel address.

A repeat count is held until the next data byte arrives. That byte is then emitted once more than the count, so a count of 0 yields one copy and a count of 127 yields 128 copies. A channel-address command drops any held count and produces a one-cycle strobe carrying the 7-bit address. The input side and the output side both use valid/ready handshakes. While copies of a run are still owed downstream, the input stays closed. The block does no compression and handles no forward-direction traffic.

Top module: `ecp_rle_expander`

## Requirements
- R1: A data byte (rx_is_cmd = 0) with no count held is emitted exactly once, with its value unchanged, and appears on tx_valid/tx_byte in the cycle after it is accepted.
- R2: A command byte whose bit 7 is 0 holds a count N taken from bits 6:0. The next data byte is then emitted N+1 times, so N = 0 gives one copy and N = 127 gives 128 copies.
- R3: When a second count command arrives before any data byte, the newer count replaces the older one.
- R4: A command byte whose bit 7 is 1 raises chan_stb for exactly one cycle, in the cycle after it is accepted, with chan_addr equal to its bits 6:0. It also discards any held count.
- R5: rx_ready is low while tx_valid is high and further copies remain. rx_ready rises in the cycle in which the final copy can be taken.
- R6: While tx_valid is high and tx_ready is low, tx_valid and tx_byte hold their values into the next cycle.
- R7: A synchronous reset (rst high at a clock edge) clears the held count and the repeat counter, drops tx_valid and chan_stb, and leaves rx_ready high.
- R8: Command bytes never produce output bytes. After a command is accepted, tx_valid is low in the next cycle.
- R9: A held count is used by exactly one data byte. The data byte after the run passes through once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Incoming byte is present |
| rx_is_cmd | input | 1 | Incoming byte is a command (1) or data (0) |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block accepts the incoming byte |
| tx_valid | output | 1 | Output byte is present |
| tx_byte | output | 8 | Output byte |
| tx_ready | input | 1 | Downstream accepts the output byte |
| chan_stb | output | 1 | One-cycle strobe for a channel-address command |
| chan_addr | output | 7 | Channel address carried by the strobe |

## Verification
The in-RTL properties watch local relationships on every cycle. These are output stability under back-pressure, the closed input while copies remain, the one-cycle address strobe, the copy count loaded from the held count, and the absence of output after commands and after reset. Only the bench scenarios can show that whole runs come out with the right length and content. The bench sweeps every count from 0 to 127 under random back-pressure, covers count replacement, counts cancelled by an address or by reset, and checks that a count is consumed once.

// File: rtl/ecp_rle_pkg.sv
package ecp_rle_pkg;

   typedef enum logic [1:0] {
      KIND_DATA  = 2'd0,
      KIND_COUNT = 2'd1,
      KIND_ADDR  = 2'd2
   } rx_kind_e;

endpackage

// File: rtl/ecp_rle_classify.sv
module ecp_rle_classify
   import ecp_rle_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int FLD_W = BYTE_W - 1
) (
   input  logic              is_cmd,
   input  logic [BYTE_W-1:0] byte_in,
   output rx_kind_e          kind,
   output logic [FLD_W-1:0]  field
);

   // The top bit of a command selects address (1) or repeat count (0).
   always_comb begin
      field = byte_in[FLD_W-1:0];
      if (!is_cmd)
         kind = KIND_DATA;
      else if (byte_in[BYTE_W-1])
         kind = KIND_ADDR;
      else
         kind = KIND_COUNT;
   end

endmodule

// File: rtl/ecp_rle_pending.sv
module ecp_rle_pending #(
   parameter int FLD_W    = 7,
   parameter bit ADDR_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_cnt,
   input  logic             load_addr,
   input  logic             consume,
   input  logic [FLD_W-1:0] field,
   output logic             pend_valid,
   output logic [FLD_W-1:0] pend_cnt,
   output logic             addr_stb,
   output logic [FLD_W-1:0] addr_val
);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_valid <= 1'b0;
         pend_cnt   <= '0;
      end else if (load_addr) begin
         pend_valid <= 1'b0;
      end else if (load_cnt) begin
         pend_valid <= 1'b1;
         pend_cnt   <= field;
      end else if (consume) begin
         pend_valid <= 1'b0;
      end
   end

   generate
      if (ADDR_REG) begin : g_addr_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               addr_stb <= 1'b0;
               addr_val <= '0;
            end else begin
               addr_stb <= load_addr;
               if (load_addr)
                  addr_val <= field;
            end
         end

         a_r4_addr_strobe: assert property (@(posedge clk) disable iff (rst)
            load_addr |=> addr_stb && addr_val == $past(field) && !pend_valid);
      end else begin : g_addr_comb
         assign addr_stb = load_addr;
         assign addr_val = field;
      end
   endgenerate

   a_r3_count_replaced: assert property (@(posedge clk) disable iff (rst)
      load_cnt && !load_addr |=> pend_valid && pend_cnt == $past(field));

endmodule

// File: rtl/ecp_rle_repeat.sv
module ecp_rle_repeat #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic [CNT_W-1:0]  seed,
   input  logic [BYTE_W-1:0] din,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte,
   output logic              last
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         remain    <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         out_byte  <= din;
         remain    <= seed;
      end else if (out_valid && out_ready) begin
         if (remain != '0)
            remain <= remain - 1'b1;
         else
            out_valid <= 1'b0;
      end
   end

   assign last = (remain == '0);

   a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(remain));

   a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && !take && remain != '0 |=> out_valid && remain == $past(remain) - 1'b1);

endmodule

// File: rtl/ecp_rle_expander.sv
module ecp_rle_expander
   import ecp_rle_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter bit ADDR_REG = 1'b1,
   localparam int FLD_W   = BYTE_W - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_valid,
   input  logic              rx_is_cmd,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_byte,
   input  logic              tx_ready,
   output logic              chan_stb,
   output logic [FLD_W-1:0]  chan_addr
);

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("ecp_rle_expander: BYTE_W must be 8");
      end
   endgenerate

   rx_kind_e         kind;
   logic [FLD_W-1:0] field;
   logic             rx_fire;
   logic             take;
   logic             pend_valid;
   logic [FLD_W-1:0] pend_cnt;
   logic [FLD_W-1:0] seed;
   logic             last;

   ecp_rle_classify #(.BYTE_W(BYTE_W)) u_cls (
      .is_cmd  (rx_is_cmd),
      .byte_in (rx_byte),
      .kind    (kind),
      .field   (field)
   );

   assign rx_ready = !tx_valid || (tx_ready && last);
   assign rx_fire  = rx_valid && rx_ready;
   assign take     = rx_fire && (kind == KIND_DATA);
   assign seed     = pend_valid ? pend_cnt : '0;

   ecp_rle_pending #(.FLD_W(FLD_W), .ADDR_REG(ADDR_REG)) u_pend (
      .clk        (clk),
      .rst        (rst),
      .load_cnt   (rx_fire && kind == KIND_COUNT),
      .load_addr  (rx_fire && kind == KIND_ADDR),
      .consume    (take),
      .field      (field),
      .pend_valid (pend_valid),
      .pend_cnt   (pend_cnt),
      .addr_stb   (chan_stb),
      .addr_val   (chan_addr)
   );

   ecp_rle_repeat #(.BYTE_W(BYTE_W), .CNT_W(FLD_W)) u_rep (
      .clk       (clk),
      .rst       (rst),
      .take      (take),
      .seed      (seed),
      .din       (rx_byte),
      .out_ready (tx_ready),
      .out_valid (tx_valid),
      .out_byte  (tx_byte),
      .last      (last)
   );

   a_r1_data_forwarded: assert property (@(posedge clk) disable iff (rst)
      rx_valid && rx_ready && !rx_is_cmd |=> tx_valid && tx_byte == $past(rx_byte));

   a_r5_input_closed: assert property (@(posedge clk) disable iff (rst)
      tx_valid && !last |-> !rx_ready);

   a_r8_cmd_no_output: assert property (@(posedge clk) disable iff (rst)
      rx_valid && rx_ready && rx_is_cmd |=> !tx_valid);

   a_r9_count_consumed: assert property (@(posedge clk) disable iff (rst)
      take |=> !pend_valid);

   a_r7_reset_clears: assert property (@(posedge clk)
      $past(rst) |-> !tx_valid && !pend_valid);

endmodule

// File: tb/test_ecp_rle_expander.sv
module test_ecp_rle_expander;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_valid = 1'b0;
   logic       rx_is_cmd = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       rx_ready;
   logic       tx_valid;
   logic [7:0] tx_byte;
   logic       tx_ready;
   logic       chan_stb;
   logic [6:0] chan_addr;

   always #5 clk = ~clk;

   ecp_rle_expander i_ecp_rle_expander (
      .clk       (clk),
      .rst       (rst),
      .rx_valid  (rx_valid),
      .rx_is_cmd (rx_is_cmd),
      .rx_byte   (rx_byte),
      .rx_ready  (rx_ready),
      .tx_valid  (tx_valid),
      .tx_byte   (tx_byte),
      .tx_ready  (tx_ready),
      .chan_stb  (chan_stb),
      .chan_addr (chan_addr)
   );

   int vecs = 0;
   int fails = 0;
   int cyc = 0;
   int ready_mode = 1;   // 0 low, 1 high, 2 random
   logic [15:0] lfsr = 16'hACE1;

   logic [7:0] got [0:16383];
   logic [7:0] expv [0:16383];
   logic [6:0] addr_got [0:255];
   int ng = 0;
   int ne = 0;
   int na = 0;
   logic prev_stall = 1'b0;
   logic [7:0] prev_byte = 8'h00;

   // Downstream ready driver
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
         0: tx_ready = 1'b0;
         1: tx_ready = 1'b1;
         default: tx_ready = lfsr[0];
      endcase
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp_val);
      vecs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp_val);
      end
   endtask

   // Monitor: samples at the falling edge
   always @(negedge clk) begin
      if (!rst) begin
         if (prev_stall)
            chk(tx_valid && tx_byte == prev_byte, "R6", {tx_valid, tx_byte}, {1'b1, prev_byte});
         if (tx_valid && tx_ready) begin
            got[ng] = tx_byte;
            ng++;
         end
         if (chan_stb) begin
            addr_got[na] = chan_addr;
            na++;
         end
         prev_stall = tx_valid && !tx_ready;
         prev_byte  = tx_byte;
      end else begin
         prev_stall = 1'b0;
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         finish_run();
      end
   end

   task automatic send(input logic c, input logic [7:0] b);
      @(posedge clk);
      #1;
      rx_valid  = 1'b1;
      rx_is_cmd = c;
      rx_byte   = b;
      do @(negedge clk); while (!rx_ready);
      @(posedge clk);
      #1;
      rx_valid = 1'b0;
   endtask

   task automatic push_exp(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         expv[ne] = b;
         ne++;
      end
   endtask

   task automatic drain();
      do @(negedge clk); while (tx_valid);
      repeat (3) @(negedge clk);
   endtask

   task automatic compare(input string req);
      chk(ng == ne, req, ng, ne);
      for (int i = 0; i < ne; i++)
         chk(i < ng && got[i] == expv[i], req, got[i], expv[i]);
      ng = 0;
      ne = 0;
   endtask

   task automatic pulse_reset();
      @(posedge clk);
      #1 rst = 1'b1;
      @(posedge clk);
      #1 rst = 1'b0;
   endtask

   initial begin
      tx_ready = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R7: state after reset
      @(negedge clk);
      chk(!tx_valid && !chan_stb && rx_ready, "R7", {tx_valid, chan_stb, rx_ready}, 3'b001);

      // R1: every data value passes once
      ready_mode = 1;
      for (int v = 0; v < 256; v++) begin
         send(1'b0, 8'(v));
         push_exp(8'(v), 1);
      end
      drain();
      compare("R1");

      // R2: every count 0..127 under random back-pressure
      ready_mode = 2;
      for (int n = 0; n < 128; n++) begin
         send(1'b1, 8'(n));
         send(1'b0, 8'(n) ^ 8'hA5);
         push_exp(8'(n) ^ 8'hA5, n + 1);
      end
      ready_mode = 1;
      drain();
      compare("R2");

      // R3: second count replaces first
      send(1'b1, 8'd5);
      send(1'b1, 8'd2);
      send(1'b0, 8'h3C);
      push_exp(8'h3C, 3);
      drain();
      compare("R3");

      // R4: address command strobes and cancels held count
      na = 0;
      send(1'b1, 8'd9);
      send(1'b1, 8'hD5);
      send(1'b0, 8'h11);
      push_exp(8'h11, 1);
      drain();
      compare("R4");
      chk(na == 1 && addr_got[0] == 7'h55, "R4", addr_got[0], 7'h55);
      na = 0;
      for (int a = 0; a < 128; a++)
         send(1'b1, 8'h80 | 8'(a));
      repeat (3) @(negedge clk);
      chk(na == 128, "R4", na, 128);
      for (int a = 0; a < 128; a++)
         chk(addr_got[a] == 7'(a), "R4", addr_got[a], a);

      // R9: held count serves one data byte only
      send(1'b1, 8'd3);
      send(1'b0, 8'hA1);
      send(1'b0, 8'hB2);
      push_exp(8'hA1, 4);
      push_exp(8'hB2, 1);
      drain();
      compare("R9");

      // R8: commands alone produce no output
      na = 0;
      send(1'b1, 8'd3);
      send(1'b1, 8'h80);
      send(1'b1, 8'd0);
      send(1'b1, 8'd127);
      send(1'b1, 8'hFF);
      repeat (4) @(negedge clk);
      chk(ng == 0, "R8", ng, 0);
      chk(na == 2, "R8", na, 2);
      send(1'b0, 8'h5A);
      push_exp(8'h5A, 1);
      drain();
      compare("R8");

      // R5: input closed until final copy
      send(1'b1, 8'd4);
      send(1'b0, 8'h77);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(tx_valid && tx_byte == 8'h77, "R5", tx_byte, 8'h77);
         chk(rx_ready == (k == 4), "R5", rx_ready, (k == 4));
      end
      push_exp(8'h77, 5);
      drain();
      compare("R5");

      // R7: reset in the middle of a stalled run
      ready_mode = 0;
      send(1'b1, 8'd50);
      send(1'b0, 8'h99);
      pulse_reset();
      @(negedge clk);
      chk(!tx_valid && rx_ready, "R7", {tx_valid, rx_ready}, 2'b01);
      ng = 0;
      ne = 0;
      send(1'b1, 8'd7);
      pulse_reset();
      ready_mode = 1;
      send(1'b0, 8'h43);
      push_exp(8'h43, 1);
      drain();
      compare("R7");

      finish_run();
   end

endmodule